// File: doc/BRIEF.md
# Event-driven UART peripheral

This block is a memory-mapped serial port steered through one-shot task registers and sticky event registers instead of a status word. Software writes a 1 to a task register to arm the receiver, start the transmitter or suspend it. It then watches per-byte event registers, which stay at 1 until software writes 0 to them. Received bytes land in a one-byte holding register. Each write to the transmit-data register sends one byte as an 8N1 frame at a fixed bit period.

The register bus is 32 bits wide and word addressed. Writes take effect at the clock edge. Reads return combinationally from the addressed register. An interrupt mask is changed only through separate set and clear registers. The interrupt line is the OR, over both events, of each event bit ANDed with its mask bit. The receiver passes the serial input through a synchronizer, samples on a 16x oversampling tick, and checks that a start bit is still low at mid-bit.

Top module: `evt_uart`

Word addresses: 0 arm-receive task, 1 start-transmit task, 2 suspend-transmit task, 3 receive-ready event, 4 transmit-ready event, 5 interrupt mask (read), 6 mask set, 7 mask clear, 8 enable, 9 receive data, 10 transmit data. Every other address is unmapped. A task fires when bit 0 of the written word is 1. Events read back in bit 0.

## Requirements
- R1: The block is active only while the enable field (bits 3:0 of word 8) holds 4. While it holds any other value, incoming frames raise no event, word 9 reads 0, and transmit-data writes send nothing. Disabling also disarms the receiver and stops the transmitter.
- R2: A frame is accepted only after a write of 1 to word 0 while the block is enabled. Frames that arrive before that raise no event.
- R3: Each accepted frame sets the receive-ready event (word 3, bit 0). The event stays 1 until a write to word 3 with bit 0 equal to 0. A write with bit 0 equal to 1 leaves it unchanged.
- R4: Word 9 returns the data bits of the most recently accepted frame. Successive frames are delivered in arrival order, one event per frame.
- R5: A write to word 6 sets the mask bits selected by 1s at bit 2 (receive) and bit 3 (transmit). A write to word 7 clears the selected bits. Word 5 reads the mask at those bit positions, and all other bits read 0.
- R6: After a write of 1 to word 1, a write to word 10 starts a frame on the clock edge that takes the write. The frame is one low start bit, then the 8 data bits LSB first, then one high stop bit, each bit lasting 32 clocks. The line is high when idle.
- R7: The transmit-ready event (word 4, bit 0) is set when the stop bit has completed. It is sticky and is cleared by a write with bit 0 equal to 0.
- R8: After a write of 1 to word 2, writes to word 10 are discarded. A later write of 1 to word 1 restores sending for the bytes written after it.
- R9: The interrupt output is high exactly when some event bit is 1 together with its mask bit.
- R10: A start bit that is low for less than half a bit period is rejected. A frame whose stop bit is sampled low is discarded. After either, the receiver accepts the next well-formed frame.
- R11: All registers read 0 after reset. Reads of unmapped addresses and of task words return 0, and writes to unmapped addresses change nothing.
- R12: A write to word 10 while a frame is still being shifted out is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus carries at most one access per cycle. They also assume that incoming frames keep to the fixed bit period closely enough for a mid-bit sample to land inside each bit. The stimulus keeps to this by driving every serial bit for exactly 32 clocks, changing inputs only on falling clock edges, and holding each bus write for exactly one rising edge. The only deliberate violations are the short start glitch and the low stop bit, which exercise the rejection paths.

// File: rtl/evt_uart_pkg.sv
package evt_uart_pkg;
   localparam int unsigned REG_RX_GO    = 0;
   localparam int unsigned REG_TX_GO    = 1;
   localparam int unsigned REG_TX_HOLD  = 2;
   localparam int unsigned REG_RX_EVT   = 3;
   localparam int unsigned REG_TX_EVT   = 4;
   localparam int unsigned REG_IRQ_MASK = 5;
   localparam int unsigned REG_IRQ_SET  = 6;
   localparam int unsigned REG_IRQ_CLR  = 7;
   localparam int unsigned REG_CTRL_EN  = 8;
   localparam int unsigned REG_RX_BYTE  = 9;
   localparam int unsigned REG_TX_BYTE  = 10;

   localparam int unsigned EN_KEY     = 4;
   localparam int unsigned IRQ_RX_BIT = 2;
   localparam int unsigned IRQ_TX_BIT = 3;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;
endpackage

// File: rtl/evt_uart_tick.sv
module evt_uart_tick #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   initial begin
      if (DIV < 1) $error("evt_uart_tick: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/evt_uart_rx.sv
module evt_uart_rx
   import evt_uart_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       rxd,
   output logic       valid,
   output logic [7:0] data
);
   localparam int unsigned CW = $clog2(OVS);
   localparam logic [CW-1:0] FULL = CW'(OVS - 1);
   localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);

   initial begin
      if (OVS < 4 || (OVS % 2) != 0) $error("evt_uart_rx: OVS must be even and at least 4");
      if (SYNC_STAGES < 2)           $error("evt_uart_rx: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= rxd;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b1;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign line = sync_q[SYNC_STAGES-1];

   rx_state_e     state_q;
   logic [CW-1:0] cnt_q;
   logic [2:0]    bitn_q;
   logic [7:0]    shreg_q;
   logic          prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         bitn_q  <= '0;
         shreg_q <= '0;
         prev_q  <= 1'b1;
         valid   <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (tick) prev_q <= line;
         if (!en) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
         end else if (tick) begin
            unique case (state_q)
               RX_IDLE: begin
                  cnt_q <= '0;
                  if (prev_q && !line) state_q <= RX_START;
               end
               RX_START: begin
                  if (cnt_q == HALF) begin
                     cnt_q  <= '0;
                     bitn_q <= '0;
                     state_q <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt_q == FULL) begin
                     cnt_q   <= '0;
                     shreg_q <= {line, shreg_q[7:1]};
                     if (bitn_q == 3'd7) state_q <= RX_STOP;
                     else                bitn_q  <= bitn_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt_q == FULL) begin
                     cnt_q   <= '0;
                     state_q <= RX_IDLE;
                     valid   <= line;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign data = shreg_q;

   // R10: a delivered frame always leaves the receiver back in idle
   p_valid_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (state_q == RX_IDLE));

   // R1: nothing is delivered while the block is disabled
   p_no_valid_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !valid);
endmodule

// File: rtl/evt_uart_tx.sv
module evt_uart_tx #(
   parameter int unsigned BIT_CLKS = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] din,
   output logic       txd,
   output logic       busy,
   output logic       done
);
   localparam int unsigned CW = $clog2(BIT_CLKS);
   localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

   initial begin
      if (BIT_CLKS < 2) $error("evt_uart_tx: BIT_CLKS must be at least 2");
   end

   logic [9:0]    shreg_q;
   logic [CW-1:0] cnt_q;
   logic [3:0]    bitn_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '1;
         cnt_q   <= '0;
         bitn_q  <= '0;
         busy_q  <= 1'b0;
      end else if (load) begin
         shreg_q <= {1'b1, din, 1'b0};
         cnt_q   <= '0;
         bitn_q  <= '0;
         busy_q  <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == LAST) begin
            cnt_q <= '0;
            if (bitn_q == 4'd9) begin
               busy_q <= 1'b0;
            end else begin
               shreg_q <= {1'b1, shreg_q[9:1]};
               bitn_q  <= bitn_q + 1'b1;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == LAST) && (bitn_q == 4'd9);
   assign txd  = busy_q ? shreg_q[0] : 1'b1;

   // R12: a new byte is never loaded over a frame in flight
   p_load_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy_q);

   // R6: the edge that takes a byte drives the start bit low
   p_start_bit_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (busy && !txd));

   // R6: the last bit slot of a frame is the high stop bit
   p_stop_bit_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> txd);

   // R7: completion ends the frame
   p_done_ends_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

// File: rtl/evt_uart.sv
module evt_uart
   import evt_uart_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned EN_W        = 4,
   parameter int unsigned OVS         = 16,
   parameter int unsigned OVS_DIV     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rxd,
   output logic              txd,
   output logic              irq
);
   localparam int unsigned BIT_CLKS = OVS * OVS_DIV;

   localparam logic [ADDR_W-1:0] A_RX_GO    = ADDR_W'(REG_RX_GO);
   localparam logic [ADDR_W-1:0] A_TX_GO    = ADDR_W'(REG_TX_GO);
   localparam logic [ADDR_W-1:0] A_TX_HOLD  = ADDR_W'(REG_TX_HOLD);
   localparam logic [ADDR_W-1:0] A_RX_EVT   = ADDR_W'(REG_RX_EVT);
   localparam logic [ADDR_W-1:0] A_TX_EVT   = ADDR_W'(REG_TX_EVT);
   localparam logic [ADDR_W-1:0] A_IRQ_MASK = ADDR_W'(REG_IRQ_MASK);
   localparam logic [ADDR_W-1:0] A_IRQ_SET  = ADDR_W'(REG_IRQ_SET);
   localparam logic [ADDR_W-1:0] A_IRQ_CLR  = ADDR_W'(REG_IRQ_CLR);
   localparam logic [ADDR_W-1:0] A_CTRL_EN  = ADDR_W'(REG_CTRL_EN);
   localparam logic [ADDR_W-1:0] A_RX_BYTE  = ADDR_W'(REG_RX_BYTE);
   localparam logic [ADDR_W-1:0] A_TX_BYTE  = ADDR_W'(REG_TX_BYTE);
   localparam logic [EN_W-1:0]   EN_VALUE   = EN_W'(EN_KEY);

   initial begin
      if (ADDR_W < 4)                     $error("evt_uart: ADDR_W too small for the map");
      if (DATA_W < 8)                     $error("evt_uart: DATA_W must hold a byte");
      if (EN_W < 3 || EN_W > DATA_W)      $error("evt_uart: EN_W must hold the enable key");
      if (OVS_DIV < 1)                    $error("evt_uart: OVS_DIV must be at least 1");
   end

   // bus decode
   logic wr;
   assign wr = bus_sel && bus_wr;

   logic wr_rx_go, wr_tx_go, wr_tx_hold, wr_rx_evt, wr_tx_evt;
   logic wr_set, wr_clr, wr_en, wr_tx_byte;
   assign wr_rx_go   = wr && (bus_addr == A_RX_GO)   && bus_wdata[0];
   assign wr_tx_go   = wr && (bus_addr == A_TX_GO)   && bus_wdata[0];
   assign wr_tx_hold = wr && (bus_addr == A_TX_HOLD) && bus_wdata[0];
   assign wr_rx_evt  = wr && (bus_addr == A_RX_EVT);
   assign wr_tx_evt  = wr && (bus_addr == A_TX_EVT);
   assign wr_set     = wr && (bus_addr == A_IRQ_SET);
   assign wr_clr     = wr && (bus_addr == A_IRQ_CLR);
   assign wr_en      = wr && (bus_addr == A_CTRL_EN);
   assign wr_tx_byte = wr && (bus_addr == A_TX_BYTE);

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata[DATA_W-1:4];

   // state
   logic [EN_W-1:0] en_q;
   logic            enabled;
   logic            rx_armed_q, tx_run_q;
   logic            ev_rx_q, ev_tx_q;
   logic [1:0]      mask_q;
   logic [7:0]      rx_hold_q;

   assign enabled = (en_q == EN_VALUE);

   // sub-blocks
   logic       tick;
   logic       rx_valid;
   logic [7:0] rx_data;
   logic       rx_take;
   logic       tx_load, tx_busy, tx_done;

   evt_uart_tick #(.DIV(OVS_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   evt_uart_rx #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (enabled),
      .tick (tick),
      .rxd  (rxd),
      .valid(rx_valid),
      .data (rx_data)
   );

   assign tx_load = wr_tx_byte && enabled && tx_run_q && !tx_busy;
   assign rx_take = rx_valid && enabled && rx_armed_q;

   evt_uart_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
      .clk  (clk),
      .rst_n(rst_n),
      .load (tx_load),
      .din  (bus_wdata[7:0]),
      .txd  (txd),
      .busy (tx_busy),
      .done (tx_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= '0;
         rx_armed_q <= 1'b0;
         tx_run_q   <= 1'b0;
         ev_rx_q    <= 1'b0;
         ev_tx_q    <= 1'b0;
         mask_q     <= '0;
         rx_hold_q  <= '0;
      end else begin
         if (wr_en) en_q <= bus_wdata[EN_W-1:0];

         if (!enabled)      rx_armed_q <= 1'b0;
         else if (wr_rx_go) rx_armed_q <= 1'b1;

         if (!enabled)        tx_run_q <= 1'b0;
         else if (wr_tx_go)   tx_run_q <= 1'b1;
         else if (wr_tx_hold) tx_run_q <= 1'b0;

         if (rx_take)                        ev_rx_q <= 1'b1;
         else if (wr_rx_evt && !bus_wdata[0]) ev_rx_q <= 1'b0;

         if (tx_done)                        ev_tx_q <= 1'b1;
         else if (wr_tx_evt && !bus_wdata[0]) ev_tx_q <= 1'b0;

         if (rx_take) rx_hold_q <= rx_data;

         if (wr_set)
            mask_q <= mask_q | {bus_wdata[IRQ_TX_BIT], bus_wdata[IRQ_RX_BIT]};
         else if (wr_clr)
            mask_q <= mask_q & ~{bus_wdata[IRQ_TX_BIT], bus_wdata[IRQ_RX_BIT]};
      end
   end

   assign irq = (ev_rx_q && mask_q[0]) || (ev_tx_q && mask_q[1]);

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_RX_EVT:   bus_rdata[0] = ev_rx_q;
         A_TX_EVT:   bus_rdata[0] = ev_tx_q;
         A_IRQ_MASK: begin
            bus_rdata[IRQ_RX_BIT] = mask_q[0];
            bus_rdata[IRQ_TX_BIT] = mask_q[1];
         end
         A_CTRL_EN:  bus_rdata[EN_W-1:0] = en_q;
         A_RX_BYTE:  if (enabled) bus_rdata[7:0] = rx_hold_q;
         default:    bus_rdata = '0;
      endcase
   end

   // R3: the receive event persists until an explicit clear
   p_rx_evt_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rx_q && !(wr_rx_evt && !bus_wdata[0])) |=> ev_rx_q);

   // R1, R2: a receive event needs an enabled, armed block
   p_rx_evt_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_rx_q) |-> $past(enabled && rx_armed_q));

   // R7: the transmit event only follows a completed frame
   p_tx_evt_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_tx_q) |-> $past(tx_done));

   // R8: after a suspend no further byte is taken
   p_suspend_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tx_hold |=> !tx_load);

   // R9: the interrupt never fires without a pending event
   p_irq_needs_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ev_rx_q || ev_tx_q));

   // R1: disabled block reports no receive data
   p_rx_byte_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!enabled && bus_addr == A_RX_BYTE) |-> (bus_rdata == '0));
endmodule

// File: tb/evt_uart_tb.sv
`timescale 1ns/1ps
module evt_uart_tb;
   localparam int BIT_T = 32;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_wr;
   logic [5:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        rxd;
   logic        txd;
   logic        irq;

   int n_checks = 0;
   int n_errors = 0;

   always #2 clk = ~clk;

   evt_uart u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .rxd      (rxd),
      .txd      (txd),
      .irq      (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // transmit-side reference model, advanced on every rising edge
   logic [3:0] m_en;
   logic       m_run, m_busy, m_ev_tx;
   int         m_c;
   logic [9:0] m_frame;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_run = 0; m_busy = 0; m_ev_tx = 0; m_c = 0; m_frame = '1;
      end else begin
         logic wrr, acc, fin;
         wrr = bus_sel && bus_wr;
         acc = wrr && bus_addr == 6'd10 && m_en == 4 && m_run && !m_busy;
         fin = 1'b0;
         if (m_busy) begin
            if (m_c == 10*BIT_T - 1) begin m_busy = 0; fin = 1; end
            else m_c++;
         end
         if (acc) begin m_busy = 1; m_c = 0; m_frame = {1'b1, bus_wdata[7:0], 1'b0}; end
         if (m_en != 4)                                      m_run = 0;
         else if (wrr && bus_addr == 6'd1 && bus_wdata[0])   m_run = 1;
         else if (wrr && bus_addr == 6'd2 && bus_wdata[0])   m_run = 0;
         if (wrr && bus_addr == 6'd4 && !bus_wdata[0]) m_ev_tx = 0;
         if (fin) m_ev_tx = 1;
         if (wrr && bus_addr == 6'd8) m_en = bus_wdata[3:0];
      end
   end

   // R6, R8, R12: the serial output is compared with the model on every clock
   always @(negedge clk) begin
      if (rst_n) check("R6 txd line", {31'b0, txd},
                       {31'b0, (m_busy ? m_frame[m_c / BIT_T] : 1'b1)});
   end

   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic expect_reg(input string req, input logic [5:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(req, d, exp);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop_bit);
      logic [9:0] fr;
      fr = {stop_bit, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         rxd = fr[i];
         repeat (BIT_T) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_frame();
      repeat (10*BIT_T + 6) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      string hello;
      string world;
      hello = "hello";
      world = "world";
      rst_n = 0; rxd = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R11 reset state
      for (int a = 0; a < 16; a++) expect_reg("R11 reset read", 6'(a), 32'h0);
      check("R11 reset txd", {31'b0, txd}, 32'h1);
      check("R9 reset irq", {31'b0, irq}, 32'h0);

      // R1 disabled: frame ignored, arming ignored
      send_frame(8'h63, 1'b1);
      expect_reg("R1 disabled rx event", 6'd3, 32'h0);
      bus_write(6'd0, 32'h1);
      bus_write(6'd8, 32'h4);
      expect_reg("R1 enable readback", 6'd8, 32'h4);

      // R2 not yet armed
      send_frame(8'h63, 1'b1);
      expect_reg("R2 unarmed rx event", 6'd3, 32'h0);
      bus_write(6'd0, 32'h1);
      send_frame(8'h63, 1'b1);
      expect_reg("R3 rx event set", 6'd3, 32'h1);
      expect_reg("R4 rx byte", 6'd9, 32'h63);
      bus_write(6'd3, 32'h1);
      expect_reg("R3 write 1 keeps event", 6'd3, 32'h1);
      bus_write(6'd3, 32'h0);
      expect_reg("R3 write 0 clears event", 6'd3, 32'h0);

      // R5 mask set/clear
      bus_write(6'd6, 32'h4);
      expect_reg("R5 mask set rx", 6'd5, 32'h4);
      bus_write(6'd6, 32'hFFFF_FFFF);
      expect_reg("R5 mask set all", 6'd5, 32'hC);
      bus_write(6'd7, 32'h8);
      expect_reg("R5 mask clear tx", 6'd5, 32'h4);

      // R9 interrupt from receive
      check("R9 no event irq", {31'b0, irq}, 32'h0);
      send_frame(8'h5A, 1'b1);
      @(negedge clk);
      check("R9 rx irq", {31'b0, irq}, 32'h1);
      bus_write(6'd7, 32'h4);
      check("R9 masked irq", {31'b0, irq}, 32'h0);
      expect_reg("R4 byte 5A", 6'd9, 32'h5A);
      bus_write(6'd3, 32'h0);

      // R4 ordered stream
      for (int i = 0; i < 5; i++) begin
         send_frame(hello[i], 1'b1);
         expect_reg("R4 stream event", 6'd3, 32'h1);
         expect_reg("R4 stream byte", 6'd9, {24'h0, hello[i]});
         bus_write(6'd3, 32'h0);
      end

      // R10 glitch and bad stop
      @(negedge clk);
      rxd = 0;
      repeat (BIT_T/4) @(negedge clk);
      rxd = 1;
      repeat (12*BIT_T) @(negedge clk);
      expect_reg("R10 glitch rejected", 6'd3, 32'h0);
      send_frame(8'h3C, 1'b0);
      repeat (2*BIT_T) @(negedge clk);
      expect_reg("R10 bad stop dropped", 6'd3, 32'h0);
      send_frame(8'h21, 1'b1);
      expect_reg("R10 recovery event", 6'd3, 32'h1);
      expect_reg("R10 recovery byte", 6'd9, 32'h21);
      bus_write(6'd3, 32'h0);

      // R1 other enable value
      bus_write(6'd8, 32'h5);
      expect_reg("R1 rx byte reads 0", 6'd9, 32'h0);
      send_frame(8'h77, 1'b1);
      expect_reg("R1 disabled no event", 6'd3, 32'h0);
      bus_write(6'd8, 32'h4);
      expect_reg("R1 held byte returns", 6'd9, 32'h21);
      send_frame(8'h77, 1'b1);
      expect_reg("R2 disarmed by disable", 6'd3, 32'h0);

      // R6 / R7 transmit
      bus_write(6'd10, 32'h41);
      wait_frame();
      expect_reg("R6 no send before start", 6'd4, {31'b0, m_ev_tx});
      expect_reg("R6 no send event 0", 6'd4, 32'h0);
      bus_write(6'd1, 32'h1);
      bus_write(6'd10, 32'h64);
      wait_frame();
      expect_reg("R7 tx event set", 6'd4, 32'h1);
      bus_write(6'd4, 32'h1);
      expect_reg("R7 write 1 keeps", 6'd4, 32'h1);
      bus_write(6'd4, 32'h0);
      expect_reg("R7 cleared", 6'd4, 32'h0);

      // R12 write while busy dropped (txd compared every clock)
      bus_write(6'd10, 32'h55);
      bus_write(6'd10, 32'hAA);
      wait_frame();
      wait_frame();
      expect_reg("R12 one frame event", 6'd4, {31'b0, m_ev_tx});
      bus_write(6'd4, 32'h0);

      // R8 suspend
      bus_write(6'd2, 32'h1);
      bus_write(6'd10, 32'h68);
      wait_frame();
      expect_reg("R8 suspended no event", 6'd4, 32'h0);
      bus_write(6'd1, 32'h1);
      for (int i = 0; i < 5; i++) begin
         bus_write(6'd10, {24'h0, world[i]});
         wait_frame();
         expect_reg("R8 resumed event", 6'd4, 32'h1);
         bus_write(6'd4, 32'h0);
      end

      // R9 interrupt from transmit
      bus_write(6'd6, 32'h8);
      bus_write(6'd10, 32'h0F);
      wait_frame();
      check("R9 tx irq", {31'b0, irq}, 32'h1);
      bus_write(6'd4, 32'h0);
      check("R9 tx irq cleared", {31'b0, irq}, 32'h0);
      bus_write(6'd7, 32'h8);

      // R11 unmapped
      bus_write(6'd20, 32'hFFFF_FFFF);
      bus_write(6'd15, 32'hFFFF_FFFF);
      expect_reg("R11 unmapped read", 6'd20, 32'h0);
      expect_reg("R11 task read", 6'd1, 32'h0);
      expect_reg("R11 mask intact", 6'd5, 32'h0);
      expect_reg("R11 enable intact", 6'd8, 32'h4);
      expect_reg("R11 events intact", 6'd3, 32'h0);

      // R1 transmit blocked while disabled
      bus_write(6'd8, 32'h0);
      bus_write(6'd1, 32'h1);
      bus_write(6'd10, 32'h99);
      wait_frame();
      expect_reg("R1 disabled no tx event", 6'd4, 32'h0);
      check("R1 disabled txd idle", {31'b0, txd}, 32'h1);

      repeat (10) @(negedge clk);
      finish_run();
   end
endmodule